// File: doc/BRIEF.md
# Reciprocal-Table Floating-Point Divider

This block divides two 18-bit floating-point numbers and returns one quotient per clock once its pipeline is full. It never runs an iterative divide. It rewrites the divisor as its reciprocal and then multiplies that reciprocal by the dividend.

The first three stages build the reciprocal:
- Stage 1 sends the divisor fraction to an internal lookup table. In the same stage it mirrors the divisor exponent around the bias.
- Stage 2 waits while the table performs its registered read.
- Stage 3 puts the table word in place of the original fraction.

The last two stages hold a truncating significand multiplier and a normalise/pack stage. The dividend travels alongside the reciprocal so that both arrive at the multiplier together.

A word is accepted when `in_valid` is high at a rising clock edge. Its result appears later with `out_valid` raised. Zero operands, exponent underflow and exponent overflow each produce a fixed, documented output pattern. No rounding is performed, and the block raises no divide-by-zero flag.

Top module: `recip_divider`

## Requirements
- R1: Each word uses bit 17 as the sign, bits 16:10 as the exponent with bias 63, and bits 9:0 as the fraction of a significand 1.f. An exponent field of 0 means the value zero, and the only zero the block ever outputs is the all-zero word.
- R2: An operand pair accepted at a rising edge drives `out_valid` high with its quotient after the fifth rising edge, counting the accepting edge as the first.
- R3: Pairs may be accepted on consecutive edges. Results leave in acceptance order, one per clock, and none is lost or duplicated.
- R4: For a divisor fraction k, the reciprocal fraction is floor(2^21/(1024+k)) - 1024 when k is nonzero, and 0 when k is 0 (a significand of exactly 1.0).
- R5: For a divisor exponent field eb, the biased reciprocal exponent is 126 - eb when the divisor fraction is zero, and 125 - eb otherwise.
- R6: For nonzero operands, the unrounded product P = (1024+fa)*(1024+r) is formed and the exponent is ea + re - 63. If P >= 2^21, the exponent rises by 1 and the fraction is bits 20:11 of P. Otherwise the fraction is bits 19:10 of P.
- R7: A dividend whose exponent field is 0 gives the all-zero quotient, provided the divisor is nonzero.
- R8: A divisor whose exponent field is 0 gives sign = dividend sign XOR divisor sign, with all exponent and fraction bits set. This applies even when the dividend is also zero.
- R9: If the final exponent is 0 or below, the quotient is the all-zero word. If it is 128 or above, the quotient takes the R8 saturated pattern with the product sign.
- R10: While reset is high, and after reset until the first result, `out_valid` is 0 and `quotient` is all zero.
- R11: A nonzero quotient carries sign = dividend sign XOR divisor sign.
- R12: A cycle with `in_valid` low produces no result. `out_valid` is low in the cycle where that slot would have appeared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| dividend | input | 18 | Numerator word A |
| divisor | input | 18 | Denominator word B |
| out_valid | output | 1 | Quotient present this cycle |
| quotient | output | 18 | Result word A/B |

## Verification
The bench instantiates the block with its default widths: a 7-bit exponent and a 10-bit fraction. At these widths the lookup table has 1024 entries, so every entry can be swept back to back with a unity dividend, and each entry is then compared against the R4 formula.

The exponent range is also small, so both saturation and flush-to-zero can be reached directly. Every divisor exponent can be walked through with zero and nonzero fractions. Bubble patterns and random pairs run through a scoreboard that checks both the value of each result and the exact cycle in which it appears.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    // Fraction part of 2/(1 + k/2^fw), truncated; k = 0 encodes 1.0 as zero.
    function automatic int unsigned recip_frac(input int unsigned k, input int unsigned fw);
        int unsigned unit;
        int unsigned quo;
        unit = 32'd1 << fw;
        if (k == 0) begin
            return 0;
        end
        quo = (unit << (fw + 1)) / (unit + k);
        return quo - unit;
    endfunction

endpackage

// File: rtl/rdiv_recip_table.sv
module rdiv_recip_table #(
    parameter int FW = 10
) (
    input  logic          clk,
    input  logic [FW-1:0] addr,
    output logic [FW-1:0] data_q
);
    localparam int DEPTH = 1 << FW;

    logic [FW-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign entry[g] = FW'(rdiv_pkg::recip_frac(g, FW));
    end

    // registered read: data belongs to the address of the previous cycle
    always_ff @(posedge clk) begin
        data_q <= entry[addr];
    end
endmodule

// File: rtl/rdiv_front.sv
module rdiv_front #(
    parameter int EW = 7,
    parameter int FW = 10,
    parameter int XW = EW + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [EW+FW:0]       a_in,
    input  logic [EW+FW:0]       b_in,
    output logic [FW-1:0]        tbl_addr,
    input  logic [FW-1:0]        tbl_data,
    output logic                 o_valid,
    output logic                 o_sign,
    output logic                 o_a_zero,
    output logic                 o_b_zero,
    output logic [EW-1:0]        o_a_exp,
    output logic [FW-1:0]        o_a_frac,
    output logic signed [XW-1:0] o_r_exp,
    output logic [FW-1:0]        o_r_frac
);
    localparam int BIAS = (1 << (EW - 1)) - 1;

    typedef struct packed {
        logic                 valid;
        logic                 sign;
        logic                 a_zero;
        logic                 b_zero;
        logic [EW-1:0]        a_exp;
        logic [FW-1:0]        a_frac;
        logic signed [XW-1:0] r_exp;
    } lane_t;

    typedef struct packed {
        lane_t         s1;
        lane_t         s2;
        lane_t         s3;
        logic [FW-1:0] b_frac1;
        logic [FW-1:0] r_frac3;
    } front_t;

    front_t state_d, state_q;

    logic [EW-1:0] a_exp_w, b_exp_w;
    logic [FW-1:0] a_frac_w, b_frac_w;

    assign a_exp_w  = a_in[EW+FW-1:FW];
    assign b_exp_w  = b_in[EW+FW-1:FW];
    assign a_frac_w = a_in[FW-1:0];
    assign b_frac_w = b_in[FW-1:0];

    always_comb begin
        state_d = state_q;
        // stage 1: table address out, exponent mirrored about the bias
        state_d.s1.valid   = in_valid;
        state_d.s1.sign    = a_in[EW+FW] ^ b_in[EW+FW];
        state_d.s1.a_zero  = (a_exp_w == '0);
        state_d.s1.b_zero  = (b_exp_w == '0);
        state_d.s1.a_exp   = a_exp_w;
        state_d.s1.a_frac  = a_frac_w;
        state_d.s1.r_exp   = XW'(2 * BIAS) - XW'(b_exp_w) - XW'(b_frac_w != '0);
        state_d.b_frac1    = b_frac_w;
        // stage 2: wait for the table word
        state_d.s2         = state_q.s1;
        // stage 3: table word replaces the divisor fraction
        state_d.s3         = state_q.s2;
        state_d.r_frac3    = tbl_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tbl_addr = state_q.b_frac1;
    assign o_valid  = state_q.s3.valid;
    assign o_sign   = state_q.s3.sign;
    assign o_a_zero = state_q.s3.a_zero;
    assign o_b_zero = state_q.s3.b_zero;
    assign o_a_exp  = state_q.s3.a_exp;
    assign o_a_frac = state_q.s3.a_frac;
    assign o_r_exp  = state_q.s3.r_exp;
    assign o_r_frac = state_q.r_frac3;
endmodule

// File: rtl/rdiv_mult.sv
module rdiv_mult #(
    parameter int EW = 7,
    parameter int FW = 10,
    parameter int XW = EW + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_valid,
    input  logic                 i_sign,
    input  logic                 i_a_zero,
    input  logic                 i_b_zero,
    input  logic [EW-1:0]        i_a_exp,
    input  logic [FW-1:0]        i_a_frac,
    input  logic signed [XW-1:0] i_r_exp,
    input  logic [FW-1:0]        i_r_frac,
    output logic                 o_valid,
    output logic [EW+FW:0]       o_word
);
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int EMAX = (1 << EW) - 1;
    localparam int PW   = 2 * FW + 2;
    localparam int PH   = FW + 2;
    localparam int W    = EW + FW + 1;
    localparam logic signed [XW-1:0] E_TOP  = XW'(EMAX);
    localparam logic signed [XW-1:0] E_ZERO = XW'(0);

    typedef struct packed {
        logic                 valid;
        logic                 sign;
        logic                 a_zero;
        logic                 b_zero;
        logic [PH-1:0]        prod_hi;
        logic signed [XW-1:0] e_sum;
    } prod_t;

    typedef struct packed {
        prod_t        s4;
        logic         valid5;
        logic [W-1:0] word5;
    } mult_t;

    mult_t state_d, state_q;

    logic signed [XW-1:0] e_norm;
    logic [FW-1:0]        f_norm;

    always_comb begin
        state_d = state_q;
        // stage 4: significand product (upper half kept) and exponent sum
        state_d.s4.valid   = i_valid;
        state_d.s4.sign    = i_sign;
        state_d.s4.a_zero  = i_a_zero;
        state_d.s4.b_zero  = i_b_zero;
        state_d.s4.prod_hi = PH'((PW'({1'b1, i_a_frac}) * PW'({1'b1, i_r_frac})) >> FW);
        state_d.s4.e_sum   = XW'(i_a_exp) + i_r_exp - XW'(BIAS);

        // stage 5: normalise, classify, pack
        if (state_q.s4.prod_hi[PH-1]) begin
            e_norm = state_q.s4.e_sum + XW'(1);
            f_norm = state_q.s4.prod_hi[PH-2 -: FW];
        end else begin
            e_norm = state_q.s4.e_sum;
            f_norm = state_q.s4.prod_hi[PH-3 -: FW];
        end

        state_d.valid5 = state_q.s4.valid;
        if (state_q.s4.valid) begin
            if (state_q.s4.b_zero) begin
                state_d.word5 = {state_q.s4.sign, {(W-1){1'b1}}};
            end else if (state_q.s4.a_zero || e_norm <= E_ZERO) begin
                state_d.word5 = '0;
            end else if (e_norm > E_TOP) begin
                state_d.word5 = {state_q.s4.sign, {(W-1){1'b1}}};
            end else begin
                state_d.word5 = {state_q.s4.sign, e_norm[EW-1:0], f_norm};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign o_valid = state_q.valid5;
    assign o_word  = state_q.word5;
endmodule

// File: rtl/recip_divider.sv
module recip_divider #(
    parameter int EXP_W  = 7,
    parameter int FRAC_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   dividend,
    input  logic [EXP_W+FRAC_W:0]   divisor,
    output logic                    out_valid,
    output logic [EXP_W+FRAC_W:0]   quotient
);
    localparam int XW = EXP_W + 3;

    logic [FRAC_W-1:0]        tbl_addr, tbl_data;
    logic                     f_valid, f_sign, f_a_zero, f_b_zero;
    logic [EXP_W-1:0]         f_a_exp;
    logic [FRAC_W-1:0]        f_a_frac, f_r_frac;
    logic signed [XW-1:0]     f_r_exp;

    rdiv_front #(.EW(EXP_W), .FW(FRAC_W), .XW(XW)) front_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .a_in     (dividend),
        .b_in     (divisor),
        .tbl_addr (tbl_addr),
        .tbl_data (tbl_data),
        .o_valid  (f_valid),
        .o_sign   (f_sign),
        .o_a_zero (f_a_zero),
        .o_b_zero (f_b_zero),
        .o_a_exp  (f_a_exp),
        .o_a_frac (f_a_frac),
        .o_r_exp  (f_r_exp),
        .o_r_frac (f_r_frac)
    );

    rdiv_recip_table #(.FW(FRAC_W)) table_i (
        .clk    (clk),
        .addr   (tbl_addr),
        .data_q (tbl_data)
    );

    rdiv_mult #(.EW(EXP_W), .FW(FRAC_W), .XW(XW)) mult_i (
        .clk      (clk),
        .rst      (rst),
        .i_valid  (f_valid),
        .i_sign   (f_sign),
        .i_a_zero (f_a_zero),
        .i_b_zero (f_b_zero),
        .i_a_exp  (f_a_exp),
        .i_a_frac (f_a_frac),
        .i_r_exp  (f_r_exp),
        .i_r_frac (f_r_frac),
        .o_valid  (out_valid),
        .o_word   (quotient)
    );
endmodule

// File: rtl/recip_divider_chk.sv
module recip_divider_chk #(
    parameter int EW = 7,
    parameter int FW = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           a_sign,
    input logic [EW-1:0]  a_exp,
    input logic           b_sign,
    input logic [EW-1:0]  b_exp,
    input logic           out_valid,
    input logic [EW+FW:0] quotient
);
    logic [2:0] age_q;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 3'd1;
        end
    end
    assign warm = (age_q >= 3'd5);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && quotient == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 5)));

    // R1
    canon_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && quotient[EW+FW-1:FW] == '0) |-> (quotient == '0));

    // R8
    divzero_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && $past(in_valid && b_exp == '0, 5))
        |-> (quotient[EW+FW-1:0] == '1 && quotient[EW+FW] == $past(a_sign ^ b_sign, 5)));

    // R7
    zero_dividend_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && $past(in_valid && a_exp == '0 && b_exp != '0, 5))
        |-> (quotient == '0));

    // R11
    sign_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && quotient[EW+FW-1:FW] != '0)
        |-> (quotient[EW+FW] == $past(a_sign ^ b_sign, 5)));
endmodule

bind recip_divider recip_divider_chk #(.EW(EXP_W), .FW(FRAC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_sign    (dividend[EXP_W+FRAC_W]),
    .a_exp     (dividend[EXP_W+FRAC_W-1:FRAC_W]),
    .b_sign    (divisor[EXP_W+FRAC_W]),
    .b_exp     (divisor[EXP_W+FRAC_W-1:FRAC_W]),
    .out_valid (out_valid),
    .quotient  (quotient)
);

// File: tb/recip_divider_tb_top.sv
module recip_divider_tb_top;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         out_valid;
    logic [W-1:0] quotient;

    always #5 clk = ~clk;

    recip_divider #(.EXP_W(7), .FRAC_W(10)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .dividend  (dividend),
        .divisor   (divisor),
        .out_valid (out_valid),
        .quotient  (quotient)
    );

    typedef struct {
        logic [W-1:0] want;
        int           due;
        string        req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    timed_out = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] mk(input int s, input int e, input int f);
        return {1'(s), 7'(e), 10'(f)};
    endfunction

    // expected quotient built from R4..R9, R11
    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        logic   s;
        int     ea, eb, fa, fb, r, re, e, f;
        longint p;
        s  = a[17] ^ b[17];
        ea = int'(a[16:10]); fa = int'(a[9:0]);
        eb = int'(b[16:10]); fb = int'(b[9:0]);
        if (eb == 0) return {s, 17'h1FFFF};
        if (ea == 0) return '0;
        r  = (fb == 0) ? 0 : (2097152 / (1024 + fb)) - 1024;
        re = 126 - eb - ((fb != 0) ? 1 : 0);
        p  = longint'(1024 + fa) * longint'(1024 + r);
        e  = ea + re - 63;
        if (p >= 64'sd2097152) begin
            e = e + 1;
            f = int'((p >> 11) & 1023);
        end else begin
            f = int'((p >> 10) & 1023);
        end
        if (e <= 0) return '0;
        if (e >= 128) return {s, 17'h1FFFF};
        return {s, 7'(e), 10'(f)};
    endfunction

    task automatic push(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        dividend = a;
        divisor  = b;
        it.want  = model(a, b);
        it.due   = cyc + 5;
        it.req   = req;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check_quiet(input string req);
        total++;
        if (out_valid !== 1'b0 || quotient !== '0) begin
            bad++;
            $display("FAIL %s quiet output: actual valid=%b q=%h expected valid=0 q=00000",
                     req, out_valid, quotient);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        item_t it;
        if (!rst) begin
            if (out_valid) begin
                total++;
                if (sb.size() == 0) begin
                    bad++;
                    $display("FAIL R12 stray result: actual %h expected none", quotient);
                end else begin
                    it = sb.pop_front();
                    if (it.due != cyc) begin
                        bad++;
                        $display("FAIL R2 timing: actual cycle %0d expected cycle %0d", cyc, it.due);
                    end else if (quotient !== it.want) begin
                        bad++;
                        $display("FAIL %s value: actual %h expected %h", it.req, quotient, it.want);
                    end
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                total++;
                bad++;
                $display("FAIL R2 missing result: actual none expected %h at cycle %0d",
                         sb[0].want, sb[0].due);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        fork
            begin : run
                repeat (3) begin
                    @(negedge clk);
                    check_quiet("R10");
                end
                rst = 1'b0;
                idle(4);
                check_quiet("R10");

                // R6: 1/1, 6/2; R4: 1/3
                push(mk(0, 63, 0),   mk(0, 63, 0),   "R6");
                push(mk(0, 65, 512), mk(0, 64, 0),   "R6");
                push(mk(0, 63, 0),   mk(0, 64, 512), "R4");
                push(mk(0, 70, 777), mk(0, 60, 301), "R6");
                // R11 sign combinations
                push(mk(1, 65, 512), mk(0, 64, 0),   "R11");
                push(mk(0, 65, 512), mk(1, 64, 0),   "R11");
                push(mk(1, 65, 512), mk(1, 64, 0),   "R11");
                // R7 zero dividend
                push(mk(1, 0, 5),    mk(0, 70, 3),   "R7");
                // R8 zero divisor, also with zero dividend
                push(mk(1, 80, 1),   mk(0, 0, 0),    "R8");
                push(mk(0, 0, 0),    mk(1, 0, 77),   "R8");
                // R9 underflow / overflow / edges of the range
                push(mk(0, 1, 0),    mk(0, 127, 1),  "R9");
                push(mk(1, 127, 1023), mk(0, 1, 0),  "R9");
                push(mk(0, 127, 0),  mk(0, 63, 0),   "R9");
                push(mk(0, 1, 0),    mk(0, 63, 0),   "R9");
                idle(2);

                // R5 every divisor exponent, zero and nonzero fraction
                for (int eb = 1; eb < 128; eb++) begin
                    push(mk(0, 63, 0), mk(0, eb, 0), "R5");
                    push(mk(0, 63, 0), mk(0, eb, 1), "R5");
                end

                // R12 bubbles between accepted pairs
                for (int i = 0; i < 12; i++) begin
                    push(mk(i % 2, 60 + i, 37 * i), mk(0, 62, 91 * i), "R12");
                    idle(1 + (i % 3));
                end

                // R4 full table sweep, back to back (R3)
                for (int k = 0; k < 1024; k++) begin
                    push(mk(0, 63, 0), mk(0, 63, k), "R4");
                end

                // R3 random back-to-back traffic
                for (int i = 0; i < 400; i++) begin
                    push(18'($urandom), 18'($urandom), "R3");
                end
                idle(12);

                total++;
                if (sb.size() != 0) begin
                    bad++;
                    $display("FAIL R3 undelivered results: actual %0d expected 0", sb.size());
                end
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog: actual hung expected completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule